// File: doc/BRIEF.md
# Dual-length serial grayscale and configuration port

This block is the serial front end of a sixteen-channel LED driver. A host clocks bits into `sdi` on the rising edge of `clk` while `le` is low. The register is one 256-bit chain. The number of shift clocks counted since the last strobe decides where the data goes when `le` rises:

- Sixteen clocks go to the configuration word.
- Two hundred fifty-six clocks go to the sixteen 16-bit grayscale channels.
- Any other count changes nothing.

The `sdo` output shows the bit leaving the far end of the active window, so several devices in a chain act as one long register. The most significant bit of the configuration word sets the window length: 0 selects 256 bits and 1 selects 16 bits.

The same `le` strobe also carries read commands. The host holds `le` high for a number of clock edges, then lowers it. The first rising edge after `le` falls is a turnaround edge. On that edge nothing shifts, and a read command loads a 16-bit word into the top of the active window. The word then leaves on `sdo`, most significant bit first. Two high edges read back the configuration word. Three or more high edges capture the fault flag input (open LED, shorted LED, over-temperature) and send it out.

Top module: `gsp_top`

## Requirements
- R1: Synchronous active-high reset clears the configuration word, all grayscale channels and the shift chain, so `sdo` reads 0.
- R2: With `le` low on this edge and the one before, each edge shifts `sdi` into bit 0. `sdo` shows the bit shifted in L edges earlier. L is 256 when config bit 15 is 0 and 16 when it is 1.
- R3: At the first `le`-high edge, if exactly 16 shift edges followed the last turnaround, the configuration word takes the last 16 bits shifted, with the first bit as bit 15. The configuration word never changes on an edge where `le` is low.
- R4: At the first `le`-high edge, if exactly 256 shift edges followed the last turnaround, each grayscale channel is loaded. Channel k takes chain bits 16k+15..16k, so channel 15 is sent first, each most significant bit first. Grayscale never changes on an edge where `le` is low.
- R5: Any other shift count leaves both the configuration word and the grayscale channels unchanged at the strobe.
- R6: Edges with `le` high shift nothing, and `sdo` holds its value while `le` stays high.
- R7: The turnaround edge shifts nothing and restarts the shift count at zero.
- R8: Holding `le` high for exactly 2 edges loads the configuration word at the turnaround edge. Holding it for 3 or more edges loads the fault flags sampled on that edge. After the turnaround, `sdo` shows bit 15, and each later shift edge shows the next lower bit.
- R9: After a read turnaround, no strobe latches anything until another turnaround has occurred.
- R10: With config bit 15 set, the 16-bit window applies to both shifting and read loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch-enable strobe and read command |
| err_flags | input | 16 | Per-channel fault status, captured on a read |
| sdo | output | 1 | Serial data out (cascade or readback) |
| cfg_word | output | 16 | Held configuration word |
| gs_data | output | 256 | Held grayscale, channel k at bits 16k+15..16k |

## Verification
The properties assume that `sdi`, `le` and `err_flags` are stable around each rising clock edge. They also assume that a change of window length comes only from a configuration latch on the first `le`-high edge, which is what the held-`sdo` check relies on. The bench changes every input on the falling edge and reads outputs there too. It starts every read or latch only after a turnaround or from a known shift count. This keeps each expected `sdo` bit computable from the bits sent, the configuration word written, or the fault word supplied.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    localparam int HOLD_W = 2;

    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_CFG  = 2'd1,
        RD_ERR  = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic     shift;
        logic     latch_cfg;
        logic     latch_gs;
        rd_kind_e rd;
    } step_ctl_t;

    // Number of edges le stayed high selects the readback source.
    function automatic rd_kind_e hold_to_read(input logic [HOLD_W-1:0] n);
        if (n >= HOLD_W'(3))      return RD_ERR;
        else if (n == HOLD_W'(2)) return RD_CFG;
        else                      return RD_NONE;
    endfunction

endpackage

// File: rtl/gsp_ctrl.sv
module gsp_ctrl
    import gsp_pkg::*;
#(
    parameter int W  = 16,
    parameter int CH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      le,
    output step_ctl_t ctl
);
    localparam int LONG  = W * CH;
    localparam int CNT_W = $clog2(LONG) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_CFG = CNT_W'(W);
    localparam logic [CNT_W-1:0] CNT_GS  = CNT_W'(LONG);

    logic              le_q;
    logic [CNT_W-1:0]  shift_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              turn;

    assign turn = !le && le_q;

    always_comb begin
        ctl = '0;
        if (le && !le_q) begin
            ctl.latch_cfg = (shift_cnt == CNT_CFG);
            ctl.latch_gs  = (shift_cnt == CNT_GS);
        end else if (turn) begin
            ctl.rd = hold_to_read(hold_cnt);
        end else if (!le) begin
            ctl.shift = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            le_q      <= 1'b0;
            shift_cnt <= '0;
            hold_cnt  <= '0;
        end else begin
            le_q <= le;
            if (le) begin
                if (!le_q)
                    hold_cnt <= HOLD_W'(1);
                else if (hold_cnt != '1)
                    hold_cnt <= hold_cnt + HOLD_W'(1);
            end
            if (turn)
                shift_cnt <= (ctl.rd != RD_NONE) ? CNT_MAX : '0;   // R9 poison after read
            else if (ctl.shift && shift_cnt != CNT_MAX)
                shift_cnt <= shift_cnt + CNT_W'(1);
        end
    end

    // R5, R7: at most one action per edge
    a_r5_one_action: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.shift, ctl.latch_cfg, ctl.latch_gs, ctl.rd != RD_NONE}));

endmodule

// File: rtl/gsp_shifter.sv
module gsp_shifter #(
    parameter int W  = 16,
    parameter int CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              shift,
    input  logic              load,
    input  logic              short_mode,
    input  logic [W-1:0]      rd_word,
    output logic [W*CH-1:0]   chain,
    output logic              sdo
);
    localparam int LONG = W * CH;

    logic [LONG-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (shift) begin
            sr_q <= {sr_q[LONG-2:0], sdi};
        end else if (load) begin
            if (short_mode)
                sr_q[W-1:0] <= rd_word;
            else
                sr_q[LONG-1 -: W] <= rd_word;
        end
    end

    assign chain = sr_q;
    assign sdo   = short_mode ? sr_q[W-1] : sr_q[LONG-1];

    // R8: loaded word appears MSB first
    a_r8_msb_first: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdo == $past(rd_word[W-1])));

endmodule

// File: rtl/gsp_hold.sv
module gsp_hold #(
    parameter int W  = 16,
    parameter int CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_cfg,
    input  logic              latch_gs,
    input  logic [W*CH-1:0]   chain,
    output logic [W-1:0]      cfg_q,
    output logic [W*CH-1:0]   gs_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (latch_cfg)
            cfg_q <= chain[W-1:0];
    end

    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic [W-1:0] chan_q;
        always_ff @(posedge clk) begin
            if (rst)
                chan_q <= '0;
            else if (latch_gs)
                chan_q <= chain[c*W +: W];
        end
        assign gs_q[c*W +: W] = chan_q;
    end

endmodule

// File: rtl/gsp_top.sv
module gsp_top
    import gsp_pkg::*;
#(
    parameter int W  = 16,
    parameter int CH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    input  logic              le,
    input  logic [W-1:0]      err_flags,
    output logic              sdo,
    output logic [W-1:0]      cfg_word,
    output logic [W*CH-1:0]   gs_data
);
    localparam int LONG = W * CH;

    step_ctl_t       ctl;
    logic [LONG-1:0] chain;
    logic [W-1:0]    rd_word;
    logic            short_mode;

    assign short_mode = cfg_word[W-1];                 // R10 window select
    assign rd_word    = (ctl.rd == RD_ERR) ? err_flags : cfg_word;

    gsp_ctrl #(.W(W), .CH(CH)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .le  (le),
        .ctl (ctl)
    );

    gsp_shifter #(.W(W), .CH(CH)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .sdi        (sdi),
        .shift      (ctl.shift),
        .load       (ctl.rd != RD_NONE),
        .short_mode (short_mode),
        .rd_word    (rd_word),
        .chain      (chain),
        .sdo        (sdo)
    );

    gsp_hold #(.W(W), .CH(CH)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .latch_cfg (ctl.latch_cfg),
        .latch_gs  (ctl.latch_gs),
        .chain     (chain),
        .cfg_q     (cfg_word),
        .gs_q      (gs_data)
    );

    a_r3_cfg_quiet: assert property (@(posedge clk) disable iff (rst)
        !le |=> $stable(cfg_word));

    a_r4_gs_quiet: assert property (@(posedge clk) disable iff (rst)
        !le |=> $stable(gs_data));

    a_r6_le_hold_sdo: assert property (@(posedge clk) disable iff (rst)
        (le && $past(le)) |=> $stable(sdo));

endmodule

// File: tb/gsp_top_test.sv
module gsp_top_test;
    localparam int  W      = 16;
    localparam int  CH     = 16;
    localparam time CLK_PD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sdi = 1'b0;
    logic          le  = 1'b0;
    logic [W-1:0]  err_flags = '0;
    logic          sdo;
    logic [W-1:0]  cfg_word;
    logic [W*CH-1:0] gs_data;

    int  vectors = 0;
    int  misses  = 0;
    bit  done    = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic hist [0:299];

    gsp_top #(.W(W), .CH(CH)) uut (
        .clk(clk), .rst(rst), .sdi(sdi), .le(le), .err_flags(err_flags),
        .sdo(sdo), .cfg_word(cfg_word), .gs_data(gs_data)
    );

    always #(CLK_PD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic d, input logic l);
        sdi = d; le = l;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic next_bit();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    function automatic logic [15:0] gs_val(input int c);
        return 16'(c * 16'h1357) ^ 16'hC0DE;
    endfunction

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) step(w[i], 1'b0);
    endtask

    task automatic pulse_le(input int n);
        repeat (n) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
    endtask

    task automatic read_word(input int n, input logic [15:0] exp, input string req);
        logic s;
        s = sdo;
        for (int j = 0; j < n; j++) begin
            step(1'b1, 1'b1);
            chk("R6 sdo held while le high", 16'(sdo), 16'(s));
        end
        step(1'b1, 1'b0);
        chk(req, 16'(sdo), 16'(exp[15]));
        for (int i = 14; i >= 0; i--) begin
            step(next_bit(), 1'b0);
            chk(req, 16'(sdo), 16'(exp[i]));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic s;
        repeat (3) step(1'b0, 1'b0);
        rst = 1'b0;
        // R1 reset state
        chk("R1 cfg reset", cfg_word, 16'h0);
        chk("R1 gs reset", 16'(gs_data != '0), 16'h0);
        chk("R1 sdo reset", 16'(sdo), 16'h0);

        // R2 long window shifting
        for (int k = 0; k < 300; k++) begin
            hist[k] = next_bit();
            step(hist[k], 1'b0);
            chk("R2 long sdo", 16'(sdo), (k >= 255) ? 16'(hist[k-255]) : 16'h0);
        end
        pulse_le(1);
        chk("R5 count 300 no cfg", cfg_word, 16'h0);
        chk("R5 count 300 no gs", 16'(gs_data != '0), 16'h0);

        // R4 grayscale latch
        for (int c = CH-1; c >= 0; c--) send_word(gs_val(c));
        pulse_le(1);
        for (int c = 0; c < CH; c++)
            chk("R4 channel", gs_data[c*W +: W], gs_val(c));

        // R3 config latch
        send_word(16'h1234);
        pulse_le(1);
        chk("R3 cfg latch", cfg_word, 16'h1234);
        chk("R3 gs untouched", gs_data[0 +: W], gs_val(0));

        // R5 wrong counts
        for (int i = 0; i < 15; i++) step(1'b1, 1'b0);
        pulse_le(1);
        chk("R5 count 15", cfg_word, 16'h1234);
        for (int i = 0; i < 17; i++) step(1'b1, 1'b0);
        pulse_le(1);
        chk("R5 count 17", cfg_word, 16'h1234);
        for (int i = 0; i < 255; i++) step(1'b1, 1'b0);
        pulse_le(1);
        chk("R5 count 255 ch0", gs_data[0 +: W], gs_val(0));
        chk("R5 count 255 ch15", gs_data[15*W +: W], gs_val(15));

        // R7 turnaround does not shift
        s = sdo;
        step(~s, 1'b1);
        step(~s, 1'b0);
        chk("R7 turnaround no shift", 16'(sdo), 16'(s));

        // R8 config readback, R9 no latch afterwards
        read_word(2, 16'h1234, "R8 cfg read");
        step(1'b0, 1'b0);
        pulse_le(1);
        chk("R9 no latch after read", cfg_word, 16'h1234);

        // R8 fault flags, walking one
        for (int i = 0; i < 16; i++) begin
            err_flags = 16'h1 << i;
            read_word(3 + (i % 2), 16'h1 << i, "R8 err read");
        end

        // R10 short window
        pulse_le(1);
        send_word(16'h8ABC);
        pulse_le(1);
        chk("R10 cfg short set", cfg_word, 16'h8ABC);
        chk("R10 short sdo start", 16'(sdo), 16'h1);
        for (int k = 0; k < 40; k++) begin
            hist[k] = next_bit();
            step(hist[k], 1'b0);
            chk("R10 short sdo", 16'(sdo),
                (k >= 15) ? 16'(hist[k-15]) : 16'(16'h8ABC >> (14 - k)) & 16'h1);
        end
        read_word(2, 16'h8ABC, "R10 short cfg read");
        err_flags = 16'h5A3C;
        read_word(5, 16'h5A3C, "R10 short err read");

        // back to long window
        pulse_le(1);
        send_word(16'h0042);
        pulse_le(1);
        chk("R3 cfg relatch", cfg_word, 16'h0042);

        // R1 reset mid-run
        rst = 1'b1;
        step(1'b0, 1'b0);
        rst = 1'b0;
        chk("R1 cfg cleared", cfg_word, 16'h0);
        chk("R1 gs cleared", 16'(gs_data != '0), 16'h0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule